// File: doc/BRIEF.md
# DS0 Signaling-Frame Alignment Delay Buffer

This block is one DS0 channel's path through a switch whose input and output DS1 streams are not frame-aligned. Robbed-bit signaling sits in the last bit of each channel byte every sixth frame. The block holds every incoming byte for a whole number of frames, from one to six. The hold time is picked so that a byte taken from an incoming signaling frame is always sent in an outgoing signaling frame. No voice bit ever takes the place of a signaling bit, and no signaling bit takes the place of a voice bit. A full 12- or 24-frame superframe alignment is never attempted, so the one-way delay stays within six frames.

Matching the frame phase does not make the signaling letters agree, so an incoming A can land in an outgoing C. To handle this, each letter's latest state is captured into a small side store when its incoming signaling frame arrives. It is written back into the byte of the outgoing frame that carries the same letter. The framer supplies one `tick` per frame together with the incoming and outgoing frame indices, and it asserts `realign` whenever the two framings have moved relative to each other. The block keeps no framing and handles no slips itself.

Top module: `ds0sa_align_buf`

## Requirements
- R1: After reset, `out_byte` is 0xFF. It remains 0xFF on every tick until the first tick that has `realign` high.
- R2: Frame indices count from 0, and the phase is index mod 6. On a realign tick the lag becomes ((incoming phase − outgoing phase) mod 6) frames, with a result of 0 taken as 6. Once the fill is complete, the byte sent on a tick is the byte that was accepted that many ticks earlier.
- R3: A byte sent in an outgoing signaling frame (phase 5) always came from an incoming signaling frame (phase 5), and its bits 7..1 are unchanged.
- R4: On a tick whose incoming index has phase 5, bit 0 of `in_byte` is stored as the state of letter index/6 (0 = A, 1 = B, 2 = C, 3 = D). In an outgoing signaling frame, bit 0 of the sent byte is the stored state of letter `out_fidx`/6, as it stood before the current tick.
- R5: In frames that are not signaling frames, all eight bits of the delayed byte are sent unchanged.
- R6: On the realign tick and on the following lag−1 ticks, `out_byte` is 0xFF. On the tick after those, live data starts.
- R7: The lag changes only on a realign tick. If the outgoing index jumps without a realign, the data lag stays the same and the signaling letter follows the new index.
- R8: On a cycle where `tick` is low, the block ignores `realign`, `in_byte` and the frame indices, stores nothing, and `out_byte` holds its value.
- R9: The 12-frame format, with letters A and B and indices 0..11, gets the same lag rule and the same letter remapping as the 24-frame format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One pulse per frame; it qualifies every other input |
| realign | input | 1 | Recompute the lag from this tick's phases |
| in_byte | input | 8 | Channel byte of the incoming frame; bit 0 is the signaling bit position |
| in_fidx | input | 5 | Superframe index of the incoming frame (0..11 or 0..23) |
| out_fidx | input | 5 | Superframe index of the outgoing frame being filled |
| out_byte | output | 8 | Channel byte for the outgoing frame |

## Verification
`out_byte` is a register that loads on the same clock edge that samples `tick`. Every tick's result is therefore due one edge after its stimulus is driven. The bench drives on the falling edge and samples 1 ns after the next rising edge. A data byte accepted on tick k comes out on tick k+lag, which is lag edges later. After a realign the output is 0xFF for exactly lag ticks. The bench keeps its own history of accepted bytes and a per-letter state model that is updated only after each tick's expectation is formed. Idle cycles between ticks are checked to leave the output untouched.

// File: rtl/ds0sa_pkg.sv
package ds0sa_pkg;

    localparam int BYTE_W     = 8;
    localparam int SIG_PERIOD = 6;
    localparam int MAX_FRAMES = 24;
    localparam int FIDX_W     = $clog2(MAX_FRAMES);
    localparam int PH_W       = $clog2(SIG_PERIOD);
    localparam int LETTERS    = MAX_FRAMES / SIG_PERIOD;
    localparam int LET_W      = $clog2(LETTERS);
    localparam int HIST_DEPTH = SIG_PERIOD + 1;
    localparam int PTR_W      = $clog2(HIST_DEPTH);
    localparam int DLY_W      = $clog2(SIG_PERIOD + 1);

    localparam logic [BYTE_W-1:0] IDLE_CODE = '1;

    // Where a frame sits inside the signaling cycle
    typedef struct packed {
        logic             is_sig;
        logic [LET_W-1:0] letter;
        logic [PH_W-1:0]  phase;
    } fpos_t;

    // Source chosen for the outgoing byte
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_DATA = 2'd1,
        SRC_SIG  = 2'd2
    } src_e;

    function automatic fpos_t locate(input logic [FIDX_W-1:0] fidx);
        fpos_t       p;
        int unsigned f;
        f        = 32'(fidx);
        p.phase  = PH_W'(f % SIG_PERIOD);
        p.letter = LET_W'(f / SIG_PERIOD);
        p.is_sig = (f % SIG_PERIOD) == 32'(SIG_PERIOD - 1);
        return p;
    endfunction

    // Frames to hold so the incoming phase reappears in the outgoing phase
    function automatic logic [DLY_W-1:0] frame_gap(input logic [PH_W-1:0] ph_in,
                                                   input logic [PH_W-1:0] ph_out);
        int unsigned d;
        d = (32'(ph_in) + 32'(SIG_PERIOD) - 32'(ph_out)) % SIG_PERIOD;
        if (d == 0) d = SIG_PERIOD;
        return DLY_W'(d);
    endfunction

endpackage

// File: rtl/ds0sa_history.sv
module ds0sa_history #(
    parameter  int DEPTH = 7,
    parameter  int WIDTH = 8,
    parameter  int LAG_W = 3,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [LAG_W-1:0] lag,
    output logic [WIDTH-1:0] rd_data,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_comb begin
        rd_ptr  = PTR_W'((32'(wr_ptr) + 32'(DEPTH) - 32'(lag)) % DEPTH);
        rd_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/ds0sa_delay_ctl.sv
module ds0sa_delay_ctl
    import ds0sa_pkg::*;
#(
    parameter int PERIOD = SIG_PERIOD,
    parameter int LAG_W  = DLY_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            realign,
    input  logic [PH_W-1:0] in_ph,
    input  logic [PH_W-1:0] out_ph,
    output logic [LAG_W-1:0] lag,
    output logic            live
);

    logic             armed;
    logic [LAG_W-1:0] filled;

    always_ff @(posedge clk) begin
        if (rst) begin
            lag    <= LAG_W'(PERIOD);
            filled <= '0;
            armed  <= 1'b0;
        end else if (tick) begin
            if (realign) begin
                lag    <= LAG_W'(frame_gap(in_ph, out_ph));
                filled <= LAG_W'(1);
                armed  <= 1'b1;
            end else if (armed && filled != LAG_W'(PERIOD)) begin
                filled <= filled + 1'b1;
            end
        end
    end

    assign live = armed && !realign && (filled >= lag);

endmodule

// File: rtl/ds0sa_sig_store.sv
module ds0sa_sig_store #(
    parameter  int LETTERS = 4,
    localparam int LET_W   = $clog2(LETTERS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [LET_W-1:0] cap_letter,
    input  logic             cap_bit,
    input  logic [LET_W-1:0] rd_letter,
    output logic             rd_bit
);

    logic [LETTERS-1:0] state;

    for (genvar i = 0; i < LETTERS; i++) begin : g_letter
        always_ff @(posedge clk) begin
            if (rst)                                    state[i] <= 1'b0;
            else if (cap_en && cap_letter == LET_W'(i)) state[i] <= cap_bit;
        end
    end

    assign rd_bit = state[rd_letter];

endmodule

// File: rtl/ds0sa_align_buf.sv
module ds0sa_align_buf
    import ds0sa_pkg::*;
#(
    parameter  int BYTE_WIDTH  = BYTE_W,
    parameter  int FRAME_IDX_W = FIDX_W,
    localparam int DEPTH       = SIG_PERIOD + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   realign,
    input  logic [BYTE_WIDTH-1:0]  in_byte,
    input  logic [FRAME_IDX_W-1:0] in_fidx,
    input  logic [FRAME_IDX_W-1:0] out_fidx,
    output logic [BYTE_WIDTH-1:0]  out_byte
);

    fpos_t                 ipos, opos;
    logic [DLY_W-1:0]      lag_w;
    logic                  live_w;
    logic [BYTE_WIDTH-1:0] delayed_w;
    logic [PTR_W-1:0]      wr_ptr_w, rd_ptr_w;
    logic                  sig_bit_w;
    src_e                  src;
    logic [BYTE_WIDTH-1:0] nxt_byte;

    assign ipos = locate(in_fidx);
    assign opos = locate(out_fidx);

    ds0sa_history #(
        .DEPTH (DEPTH),
        .WIDTH (BYTE_WIDTH),
        .LAG_W (DLY_W)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tick),
        .wr_data (in_byte),
        .lag     (lag_w),
        .rd_data (delayed_w),
        .wr_ptr  (wr_ptr_w),
        .rd_ptr  (rd_ptr_w)
    );

    ds0sa_delay_ctl #(
        .PERIOD (SIG_PERIOD),
        .LAG_W  (DLY_W)
    ) u_dly (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .realign (realign),
        .in_ph   (ipos.phase),
        .out_ph  (opos.phase),
        .lag     (lag_w),
        .live    (live_w)
    );

    ds0sa_sig_store #(
        .LETTERS (LETTERS)
    ) u_sig (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (tick && ipos.is_sig),
        .cap_letter (ipos.letter),
        .cap_bit    (in_byte[0]),
        .rd_letter  (opos.letter),
        .rd_bit     (sig_bit_w)
    );

    always_comb begin
        if (!live_w)          src = SRC_IDLE;
        else if (opos.is_sig) src = SRC_SIG;
        else                  src = SRC_DATA;
    end

    always_comb begin
        case (src)
            SRC_DATA: nxt_byte = delayed_w;
            SRC_SIG:  nxt_byte = {delayed_w[BYTE_WIDTH-1:1], sig_bit_w};
            default:  nxt_byte = IDLE_CODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       out_byte <= IDLE_CODE;
        else if (tick) out_byte <= nxt_byte;
    end

endmodule

// File: rtl/ds0sa_align_chk.sv
module ds0sa_align_chk
    import ds0sa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              realign,
    input logic [BYTE_W-1:0] out_byte,
    input logic [DLY_W-1:0]  lag,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              live
);

    // R6: a realign tick always produces the idle code
    p_idle_after_realign_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && realign) |=> (out_byte == IDLE_CODE));

    // R8: no tick, no output change
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> $stable(out_byte));

    // R2: lag always within one signaling period
    p_lag_range_r2: assert property (@(posedge clk) disable iff (rst)
        (lag >= DLY_W'(1)) && (lag <= DLY_W'(SIG_PERIOD)));

    // R3: a live read never hits the slot being written
    p_ptr_apart_r3: assert property (@(posedge clk) disable iff (rst)
        live |-> (rd_ptr != wr_ptr));

    // R7: lag moves only on a realign tick
    p_lag_kept_r7: assert property (@(posedge clk) disable iff (rst)
        !(tick && realign) |=> $stable(lag));

endmodule

bind ds0sa_align_buf ds0sa_align_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .realign  (realign),
    .out_byte (out_byte),
    .lag      (lag_w),
    .rd_ptr   (rd_ptr_w),
    .wr_ptr   (wr_ptr_w),
    .live     (live_w)
);

// File: tb/ds0sa_align_buf_tb.sv
`timescale 1ns/1ps
module ds0sa_align_buf_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       realign = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [4:0] in_fidx = 5'd0;
    logic [4:0] out_fidx = 5'd0;
    logic [7:0] out_byte;

    always #4 clk = ~clk;

    ds0sa_align_buf u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .realign  (realign),
        .in_byte  (in_byte),
        .in_fidx  (in_fidx),
        .out_fidx (out_fidx),
        .out_byte (out_byte)
    );

    // Scenario vectors: start indices, superframe length, expected lag, idle gaps
    localparam int NSC = 6;
    localparam int SC_IN  [NSC] = '{0, 5, 1, 4, 10, 23};
    localparam int SC_OUT [NSC] = '{0, 2, 5, 3, 0, 17};
    localparam int SC_LEN [NSC] = '{24, 24, 24, 24, 12, 24};
    localparam int SC_D   [NSC] = '{6, 3, 2, 1, 4, 6};
    localparam int SC_GAP [NSC] = '{0, 0, 1, 0, 0, 0};

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;
    int         g = 0, ksince = 0, dcur = 6, lens = 24, cur_in = 0, cur_out = 0;
    bit         armed_m = 1'b0;
    logic [7:0] hist [64];
    logic [3:0] sig_m = 4'b0000;

    function automatic logic [7:0] pat(input int n);
        return 8'((n * 29 + 7) ^ (n >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input bit rl);
        logic [7:0] b, e;
        string      tag;
        bit         osig;
        b = pat(g);
        @(negedge clk);
        tick = 1'b1; realign = rl; in_byte = b;
        in_fidx = 5'(cur_in); out_fidx = 5'(cur_out);
        if (rl) begin armed_m = 1'b1; ksince = 0; end
        osig = (cur_out % 6) == 5;
        if (!armed_m) begin
            e = 8'hFF; tag = "R1";
        end else if (ksince < dcur) begin
            e = 8'hFF; tag = "R6";
        end else begin
            e = hist[(g - dcur) % 64];
            if (osig) e[0] = sig_m[cur_out / 6];
            tag = (ksince == dcur) ? ((lens == 12) ? "R9" : "R2") : "R5";
        end
        // models advance only after the expectation is fixed
        hist[g % 64] = b;
        if ((cur_in % 6) == 5) sig_m[cur_in / 6] = b[0];
        g++; ksince++;
        cur_in  = (cur_in + 1) % lens;
        cur_out = (cur_out + 1) % lens;
        @(posedge clk); #1;
        if (armed_m && e != 8'hFF && osig) begin
            chk(out_byte[7:1] == e[7:1], "R3", out_byte, e);
            chk(out_byte[0] == e[0], "R4", out_byte, e);
        end else begin
            chk(out_byte == e, tag, out_byte, e);
        end
    endtask

    // Cycle with tick low and junk on every other input (R8)
    task automatic gap();
        logic [7:0] prev;
        @(negedge clk);
        prev = out_byte;
        tick = 1'b0; realign = 1'b1; in_byte = ~pat(g); in_fidx = 5'd5; out_fidx = 5'd11;
        @(posedge clk); #1;
        chk(out_byte == prev, "R8", out_byte, prev);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 chk(out_byte == 8'hFF, "R1", out_byte, 8'hFF);

        // R1: no realign yet, idle regardless of ticks
        cur_in = 3; cur_out = 0; lens = 24;
        for (int i = 0; i < 8; i++) step(1'b0);

        // Table walk: R2..R6, R9, R8 on gap scenario
        for (int s = 0; s < NSC; s++) begin
            cur_in = SC_IN[s]; cur_out = SC_OUT[s]; lens = SC_LEN[s]; dcur = SC_D[s];
            step(1'b1);
            for (int i = 0; i < 29; i++) begin
                step(1'b0);
                if (SC_GAP[s] != 0) gap();
            end
        end

        // R7: outgoing index jumps without realign; lag is kept
        cur_out = (cur_out + 2) % lens;
        for (int i = 0; i < 14; i++) step(1'b0);

        // R1: reset mid-stream returns to idle until next realign
        @(negedge clk); rst = 1'b1; tick = 1'b0;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        #1 chk(out_byte == 8'hFF, "R1", out_byte, 8'hFF);
        armed_m = 1'b0; sig_m = 4'b0000;
        for (int i = 0; i < 6; i++) step(1'b0);

        // R6/R2 after reset: short lag realign
        cur_in = 8; cur_out = 7; lens = 24; dcur = 1;
        step(1'b1);
        for (int i = 0; i < 10; i++) step(1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule